// File: doc/BRIEF.md
# Striped Word/Byte Staging Buffer

This block sits between a 32-bit register bus and a byte-serial engine and stages data in one direction. Storage is split into four byte-wide banks of 16 entries each. A word access on the bus side moves one byte in every bank in the same cycle, so the buffer holds 64 bytes when it is filled by words. A byte access on the bus side, and every access from the serial side, touches a single bank. The bank is picked by a rotating pointer, so consecutive bytes land in banks 0, 1, 2, 3 and then wrap.

A parameter selects the direction. In the transmit build, the bus pushes words or bytes and the serial engine pops bytes, least significant byte of each word first. In the receive build, the serial engine pushes bytes and the bus pops words or bytes. The block reports full, half-full and empty conditions. It also reports whether a whole word or at least one byte is ready. Any push that is refused and any pop that is refused raises an error flag, which stays set until a synchronous clear.

Top module: `bbf_banked_fifo`

## Requirements
- R1: After reset, st_empty is 1 and st_full, st_half, word_avail, byte_avail and err are all 0.
- R2: A word push stores bits 8k+7:8k in bank k. The serial side then pops the four bytes least significant first, reading banks in the order 0, 1, 2, 3 and wrapping after bank 3.
- R3: Byte accesses from the bus and from the serial side each follow their own bank pointer. That pointer starts at bank 0 and advances 0→1→2→3→0 on every accepted byte access. A word access leaves both pointers unchanged.
- R4: Each bank holds 16 bytes, so 16 word pushes fill the buffer. st_full is 1 whenever any bank holds 16 bytes.
- R5: st_half is 1 whenever any bank holds 8 or more bytes.
- R6: st_empty is 1 only when every bank is empty. word_avail is 1 only when all four banks hold data. byte_avail is 1 when the bank at the read pointer holds data.
- R7: A refused access raises err, and err stays at 1 until a clear. A push is refused when a bank it targets is full. A pop is refused when a bank it reads is empty. A refused access changes no stored data and no pointer.
- R8: If the word and byte strobes on the bus are both asserted in one cycle, only the word access is performed. The byte strobe is ignored and does not raise err.
- R9: A clear empties all banks, returns both bank pointers to 0 and clears err. It takes priority over any access in the same cycle.
- R10: A push and a pop in the same cycle are both performed. Whether each one is accepted depends only on the occupancy at the start of that cycle.
- R11: In the receive build, a word pop presents {bank3, bank2, bank1, bank0} on bus_rdata. A byte pop presents the head of the bank at the read pointer in bits 7:0, with zeros above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| clr | input | 1 | Synchronous clear of contents, pointers and err |
| bus_word | input | 1 | Bus word access strobe (push in transmit, pop in receive) |
| bus_byte | input | 1 | Bus byte access strobe (push in transmit, pop in receive) |
| bus_wdata | input | BUS_W | Bus write data; bits 7:0 are used by byte pushes |
| bus_rdata | output | BUS_W | Bus read data, valid before the pop edge (receive build) |
| ser_req | input | 1 | Serial byte access strobe (pop in transmit, push in receive) |
| ser_wdata | input | 8 | Serial write byte (receive build) |
| ser_rdata | output | 8 | Serial read byte, valid before the pop edge (transmit build) |
| st_full | output | 1 | Some bank is full |
| st_half | output | 1 | Some bank is at least half full |
| st_empty | output | 1 | All banks are empty |
| word_avail | output | 1 | All four banks hold data |
| byte_avail | output | 1 | The bank at the read pointer holds data |
| err | output | 1 | Sticky flag for a refused access |

## Verification
The properties assume that every strobe is a clean 0 or 1 once reset has been released. They also assume that the strobes and clr are sampled only at rising edges. The bench changes every input one time unit after a rising edge, so each request sits stable for one full cycle. It reads the combinational read data before the edge that performs the pop. The properties also assume that clr, when asserted, is seen for one full cycle, because the clear is checked one cycle after clr is sampled.

// File: rtl/bbf_pkg.sv
package bbf_pkg;
  localparam int unsigned BYTE_W = 8;
  typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/bbf_rst_sync.sv
module bbf_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/bbf_bank.sv
module bbf_bank #(
  parameter  int DEPTH = 16,
  parameter  int DW    = 8,
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push,
  input  logic          pop,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout,
  output logic [CW-1:0] level
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr_q, wptr_n, rptr_q, rptr_n;
  logic [CW-1:0] lvl_q, lvl_n;

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    wptr_n = wptr_q;
    rptr_n = rptr_q;
    lvl_n  = lvl_q;
    if (clr) begin
      wptr_n = '0;
      rptr_n = '0;
      lvl_n  = '0;
    end else begin
      if (push) wptr_n = step(wptr_q);
      if (pop)  rptr_n = step(rptr_q);
      lvl_n = lvl_q + CW'(push) - CW'(pop);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      lvl_q  <= '0;
    end else begin
      wptr_q <= wptr_n;
      rptr_q <= rptr_n;
      lvl_q  <= lvl_n;
    end
  end

  always_ff @(posedge clk) begin
    if (push && !clr) mem[wptr_q] <= din;
  end

  assign dout  = mem[rptr_q];
  assign level = lvl_q;
endmodule

// File: rtl/bbf_ctl.sv
module bbf_ctl #(
  parameter  int NB = 4,
  localparam int SW = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push_word,
  input  logic          push_byte,
  input  logic          pop_word,
  input  logic          pop_byte,
  input  logic [NB-1:0] bank_full,
  input  logic [NB-1:0] bank_empty,
  output logic [NB-1:0] push_en,
  output logic [NB-1:0] pop_en,
  output logic [SW-1:0] wr_sel,
  output logic [SW-1:0] rd_sel,
  output logic          err
);
  logic [SW-1:0] wr_q, wr_n, rd_q, rd_n;
  logic          err_q, err_n;
  logic          pb_try, qb_try;
  logic          push_w_ok, push_b_ok, pop_w_ok, pop_b_ok;
  logic          refused;

  function automatic logic [SW-1:0] rot(input logic [SW-1:0] s);
    return (s == SW'(NB - 1)) ? '0 : s + 1'b1;
  endfunction

  always_comb begin
    pb_try    = push_byte & ~push_word;
    qb_try    = pop_byte & ~pop_word;
    push_w_ok = push_word & ~(|bank_full);
    push_b_ok = pb_try & ~bank_full[wr_q];
    pop_w_ok  = pop_word & ~(|bank_empty);
    pop_b_ok  = qb_try & ~bank_empty[rd_q];
    refused   = (push_word & (|bank_full)) | (pb_try & bank_full[wr_q]) |
                (pop_word & (|bank_empty)) | (qb_try & bank_empty[rd_q]);
  end

  for (genvar k = 0; k < NB; k++) begin : g_en
    assign push_en[k] = ~clr & (push_w_ok | (push_b_ok & (wr_q == SW'(k))));
    assign pop_en[k]  = ~clr & (pop_w_ok  | (pop_b_ok  & (rd_q == SW'(k))));
  end

  always_comb begin
    wr_n  = wr_q;
    rd_n  = rd_q;
    err_n = err_q;
    if (clr) begin
      wr_n  = '0;
      rd_n  = '0;
      err_n = 1'b0;
    end else begin
      if (push_b_ok) wr_n = rot(wr_q);
      if (pop_b_ok)  rd_n = rot(rd_q);
      if (refused)   err_n = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      err_q <= 1'b0;
    end else begin
      wr_q  <= wr_n;
      rd_q  <= rd_n;
      err_q <= err_n;
    end
  end

  assign wr_sel = wr_q;
  assign rd_sel = rd_q;
  assign err    = err_q;
endmodule

// File: rtl/bbf_banked_fifo.sv
module bbf_banked_fifo
  import bbf_pkg::*;
#(
  parameter int BUS_W     = 32,
  parameter int DEPTH     = 16,
  parameter bit TO_SERIAL = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             bus_word,
  input  logic             bus_byte,
  input  logic [BUS_W-1:0] bus_wdata,
  output logic [BUS_W-1:0] bus_rdata,
  input  logic             ser_req,
  input  logic [7:0]       ser_wdata,
  output logic [7:0]       ser_rdata,
  output logic             st_full,
  output logic             st_half,
  output logic             st_empty,
  output logic             word_avail,
  output logic             byte_avail,
  output logic             err
);
  localparam int NB = BUS_W / BYTE_W;
  localparam int SW = (NB > 1) ? $clog2(NB) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam int HALF = DEPTH / 2;

  logic          rst_sync_n;
  logic          push_word, push_byte, pop_word, pop_byte;
  byte_t         byte_in;
  logic [NB-1:0] push_en, pop_en, bank_full, bank_empty, bank_half;
  logic [SW-1:0] wr_sel, rd_sel;
  byte_t         head [NB];
  logic [CW-1:0] lvl [NB];
  logic [BUS_W-1:0] head_word;

  bbf_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  // direction mapping: transmit build pushes from the bus, receive build from serial
  assign push_word = TO_SERIAL ? bus_word : 1'b0;
  assign push_byte = TO_SERIAL ? bus_byte : ser_req;
  assign pop_word  = TO_SERIAL ? 1'b0     : bus_word;
  assign pop_byte  = TO_SERIAL ? ser_req  : bus_byte;
  assign byte_in   = TO_SERIAL ? bus_wdata[7:0] : ser_wdata;

  bbf_ctl #(.NB(NB)) u_ctl (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .clr        (clr),
    .push_word  (push_word),
    .push_byte  (push_byte),
    .pop_word   (pop_word),
    .pop_byte   (pop_byte),
    .bank_full  (bank_full),
    .bank_empty (bank_empty),
    .push_en    (push_en),
    .pop_en     (pop_en),
    .wr_sel     (wr_sel),
    .rd_sel     (rd_sel),
    .err        (err)
  );

  for (genvar k = 0; k < NB; k++) begin : g_bank
    byte_t din_k;
    assign din_k = push_word ? bus_wdata[BYTE_W*k +: BYTE_W] : byte_in;

    bbf_bank #(.DEPTH(DEPTH), .DW(BYTE_W)) u_bank (
      .clk   (clk),
      .rst_n (rst_sync_n),
      .clr   (clr),
      .push  (push_en[k]),
      .pop   (pop_en[k]),
      .din   (din_k),
      .dout  (head[k]),
      .level (lvl[k])
    );

    assign bank_full[k]  = (lvl[k] == CW'(DEPTH));
    assign bank_half[k]  = (lvl[k] >= CW'(HALF));
    assign bank_empty[k] = (lvl[k] == '0);
    assign head_word[BYTE_W*k +: BYTE_W] = head[k];
  end

  assign st_full    = |bank_full;
  assign st_half    = |bank_half;
  assign st_empty   = &bank_empty;
  assign word_avail = ~(|bank_empty);
  assign byte_avail = ~bank_empty[rd_sel];

  assign ser_rdata = TO_SERIAL ? head[rd_sel] : 8'h00;
  assign bus_rdata = TO_SERIAL ? '0 :
                     (bus_word ? head_word : {{(BUS_W-BYTE_W){1'b0}}, head[rd_sel]});
endmodule

// File: rtl/bbf_banked_fifo_chk.sv
module bbf_banked_fifo_chk #(
  parameter bit TO_SERIAL = 1'b1
) (
  input logic clk,
  input logic rst_n,
  input logic clr,
  input logic bus_word,
  input logic bus_byte,
  input logic ser_req,
  input logic st_full,
  input logic st_half,
  input logic st_empty,
  input logic word_avail,
  input logic byte_avail,
  input logic err
);
  logic pop_try;
  assign pop_try = TO_SERIAL ? ser_req : (bus_word | bus_byte);

  // R6: a full word ready implies the read bank holds data
  a_r6_word_has_byte: assert property (@(posedge clk) disable iff (!rst_n)
    word_avail |-> byte_avail);

  // R6: a full word ready means the buffer is not empty
  a_r6_word_not_empty: assert property (@(posedge clk) disable iff (!rst_n)
    word_avail |-> !st_empty);

  // R4/R5: a full bank is also past half and the buffer is not empty
  a_r4_full_consistent: assert property (@(posedge clk) disable iff (!rst_n)
    st_full |-> (st_half && !st_empty));

  // R7: err holds until a clear
  a_r7_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (err && !clr) |=> err);

  // R7: a pop attempt on an empty buffer raises err
  a_r7_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
    (st_empty && pop_try && !clr) |=> err);

  // R9: a clear leaves the buffer empty with err low
  a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (st_empty && !err && !byte_avail && !word_avail));
endmodule

bind bbf_banked_fifo bbf_banked_fifo_chk #(.TO_SERIAL(TO_SERIAL)) chk_i (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .clr        (clr),
  .bus_word   (bus_word),
  .bus_byte   (bus_byte),
  .ser_req    (ser_req),
  .st_full    (st_full),
  .st_half    (st_half),
  .st_empty   (st_empty),
  .word_avail (word_avail),
  .byte_avail (byte_avail),
  .err        (err)
);

// File: tb/bbf_banked_fifo_tb_top.sv
module bbf_banked_fifo_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk, rst_n;
  // transmit instance
  logic clr, bus_word, bus_byte, ser_req;
  logic [31:0] bus_wdata, bus_rdata;
  logic [7:0]  ser_wdata, ser_rdata;
  logic st_full, st_half, st_empty, word_avail, byte_avail, err;
  // receive instance
  logic rclr, rbus_word, rbus_byte, rser_req;
  logic [31:0] rbus_wdata, rbus_rdata;
  logic [7:0]  rser_wdata, rser_rdata;
  logic r_full, r_half, r_empty, r_wavail, r_bavail, r_err;

  int n_checks = 0;
  int n_fail   = 0;

  bbf_banked_fifo #(.TO_SERIAL(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .clr(clr),
    .bus_word(bus_word), .bus_byte(bus_byte), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ser_req(ser_req), .ser_wdata(ser_wdata), .ser_rdata(ser_rdata),
    .st_full(st_full), .st_half(st_half), .st_empty(st_empty),
    .word_avail(word_avail), .byte_avail(byte_avail), .err(err)
  );

  bbf_banked_fifo #(.TO_SERIAL(1'b0)) dut_rx_i (
    .clk(clk), .rst_n(rst_n), .clr(rclr),
    .bus_word(rbus_word), .bus_byte(rbus_byte), .bus_wdata(rbus_wdata), .bus_rdata(rbus_rdata),
    .ser_req(rser_req), .ser_wdata(rser_wdata), .ser_rdata(rser_rdata),
    .st_full(r_full), .st_half(r_half), .st_empty(r_empty),
    .word_avail(r_wavail), .byte_avail(r_bavail), .err(r_err)
  );

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD/2) clk = ~clk;
  end

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    summary();
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic push_w(input logic [31:0] d);
    bus_word = 1'b1; bus_wdata = d;
    tick();
    bus_word = 1'b0;
  endtask

  task automatic push_b(input logic [7:0] b);
    bus_byte = 1'b1; bus_wdata = {24'h0, b};
    tick();
    bus_byte = 1'b0;
  endtask

  task automatic pop_chk(input string req, input logic [7:0] exp);
    check(req, {24'h0, ser_rdata}, {24'h0, exp});
    ser_req = 1'b1;
    tick();
    ser_req = 1'b0;
  endtask

  task automatic do_clr();
    clr = 1'b1;
    tick();
    clr = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 empty", {31'h0, st_empty}, 32'd1);
    check("R1 full", {31'h0, st_full}, 32'd0);
    check("R1 half", {31'h0, st_half}, 32'd0);
    check("R1 word_avail", {31'h0, word_avail}, 32'd0);
    check("R1 byte_avail", {31'h0, byte_avail}, 32'd0);
    check("R1 err", {31'h0, err}, 32'd0);
  endtask

  task automatic t_word_order();
    do_clr();
    push_w(32'h44332211);
    check("R6 word_avail after word", {31'h0, word_avail}, 32'd1);
    check("R6 byte_avail after word", {31'h0, byte_avail}, 32'd1);
    pop_chk("R2 byte0", 8'h11);
    check("R6 word_avail partial", {31'h0, word_avail}, 32'd0);
    pop_chk("R2 byte1", 8'h22);
    pop_chk("R2 byte2", 8'h33);
    pop_chk("R2 byte3", 8'h44);
    check("R6 empty after word", {31'h0, st_empty}, 32'd1);
    push_w(32'h88776655);
    pop_chk("R2 wrap byte0", 8'h55);
    pop_chk("R2 wrap byte1", 8'h66);
    pop_chk("R2 wrap byte2", 8'h77);
    pop_chk("R2 wrap byte3", 8'h88);
    check("R2 err clean", {31'h0, err}, 32'd0);
  endtask

  task automatic t_byte_rot();
    do_clr();
    push_b(8'hA0); push_b(8'hA1); push_b(8'hA2);
    check("R3 three bytes no word", {31'h0, word_avail}, 32'd0);
    push_b(8'hA3);
    check("R3 four bytes make word", {31'h0, word_avail}, 32'd1);
    push_b(8'hA4);
    for (int i = 0; i < 5; i++) pop_chk("R3 byte order", 8'(8'hA0 + i));
    check("R3 empty after bytes", {31'h0, st_empty}, 32'd1);
    check("R3 byte_avail low", {31'h0, byte_avail}, 32'd0);
  endtask

  task automatic t_fill();
    do_clr();
    for (int i = 0; i < 16; i++) begin
      push_w({8'(4*i+3), 8'(4*i+2), 8'(4*i+1), 8'(4*i)});
      if (i == 6) check("R5 half low at 7", {31'h0, st_half}, 32'd0);
      if (i == 7) check("R5 half at 8", {31'h0, st_half}, 32'd1);
      if (i == 14) check("R4 not full at 15", {31'h0, st_full}, 32'd0);
    end
    check("R4 full at 16 words", {31'h0, st_full}, 32'd1);
    check("R4 err before overflow", {31'h0, err}, 32'd0);
    push_w(32'hDEADBEEF);
    check("R7 overflow err", {31'h0, err}, 32'd1);
    check("R7 still full", {31'h0, st_full}, 32'd1);
    for (int i = 0; i < 64; i++) pop_chk("R7 contents intact", 8'(i));
    check("R4 empty after 64", {31'h0, st_empty}, 32'd1);
    check("R7 err sticky", {31'h0, err}, 32'd1);
    do_clr();
    check("R9 clear drops err", {31'h0, err}, 32'd0);
    ser_req = 1'b1; tick(); ser_req = 1'b0;
    check("R7 underflow err", {31'h0, err}, 32'd1);
    check("R7 underflow keeps empty", {31'h0, st_empty}, 32'd1);
  endtask

  task automatic t_both();
    do_clr();
    bus_word = 1'b1; bus_byte = 1'b1; bus_wdata = 32'h87654321;
    tick();
    bus_word = 1'b0; bus_byte = 1'b0;
    check("R8 no err", {31'h0, err}, 32'd0);
    pop_chk("R8 b0", 8'h21);
    pop_chk("R8 b1", 8'h43);
    pop_chk("R8 b2", 8'h65);
    pop_chk("R8 b3", 8'h87);
    check("R8 byte ignored", {31'h0, st_empty}, 32'd1);
  endtask

  task automatic t_clear();
    do_clr();
    push_b(8'h11); push_b(8'h22);
    clr = 1'b1; bus_word = 1'b1; bus_wdata = 32'h12345678;
    tick();
    clr = 1'b0; bus_word = 1'b0;
    check("R9 empty", {31'h0, st_empty}, 32'd1);
    check("R9 err low", {31'h0, err}, 32'd0);
    push_b(8'h77);
    check("R9 pointers at 0", {31'h0, byte_avail}, 32'd1);
    pop_chk("R9 byte after clear", 8'h77);
    check("R9 no err after", {31'h0, err}, 32'd0);
    check("R9 empty after", {31'h0, st_empty}, 32'd1);
  endtask

  task automatic t_simul();
    do_clr();
    push_w(32'h0D0C0B0A);
    check("R10 head", {24'h0, ser_rdata}, 32'h0A);
    bus_word = 1'b1; bus_wdata = 32'h1D1C1B1A; ser_req = 1'b1;
    tick();
    bus_word = 1'b0; ser_req = 1'b0;
    pop_chk("R10 s1", 8'h0B);
    pop_chk("R10 s2", 8'h0C);
    pop_chk("R10 s3", 8'h0D);
    pop_chk("R10 s4", 8'h1A);
    pop_chk("R10 s5", 8'h1B);
    pop_chk("R10 s6", 8'h1C);
    pop_chk("R10 s7", 8'h1D);
    check("R10 empty", {31'h0, st_empty}, 32'd1);
    check("R10 err clean", {31'h0, err}, 32'd0);
    bus_byte = 1'b1; bus_wdata = 32'h55; ser_req = 1'b1;
    tick();
    bus_byte = 1'b0; ser_req = 1'b0;
    check("R10 pop on empty refused", {31'h0, err}, 32'd1);
    check("R10 push still taken", {31'h0, byte_avail}, 32'd1);
    pop_chk("R10 pushed byte", 8'h55);
  endtask

  task automatic t_rx();
    rclr = 1'b1; tick(); rclr = 1'b0;
    for (int i = 0; i < 4; i++) begin
      rser_req = 1'b1; rser_wdata = 8'(8'hC1 + i);
      tick();
    end
    rser_req = 1'b0;
    check("R11 word ready", {31'h0, r_wavail}, 32'd1);
    rbus_word = 1'b1;
    #1;
    check("R11 word data", rbus_rdata, 32'hC4C3C2C1);
    tick();
    rbus_word = 1'b0;
    check("R11 empty after word", {31'h0, r_empty}, 32'd1);
    rser_req = 1'b1; rser_wdata = 8'hE5;
    tick();
    rser_req = 1'b0;
    rbus_byte = 1'b1;
    #1;
    check("R11 byte data", rbus_rdata, 32'h000000E5);
    tick();
    rbus_byte = 1'b0;
    check("R11 empty after byte", {31'h0, r_empty}, 32'd1);
    check("R11 err clean", {31'h0, r_err}, 32'd0);
  endtask

  initial begin
    rst_n = 1'b0;
    clr = 1'b0; bus_word = 1'b0; bus_byte = 1'b0; ser_req = 1'b0;
    bus_wdata = '0; ser_wdata = '0;
    rclr = 1'b0; rbus_word = 1'b0; rbus_byte = 1'b0; rser_req = 1'b0;
    rbus_wdata = '0; rser_wdata = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) tick();
    t_reset();
    t_word_order();
    t_byte_rot();
    t_fill();
    t_both();
    t_clear();
    t_simul();
    t_rx();
    summary();
  end
endmodule